// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits beside the write path of a 16-bit parallel flash model and watches each completed write cycle (its latched address and data word). It recognises a three-write key and decides what the key opens. One final word arms a sector load and emits a single-cycle enable. Two other final words schedule entry into or exit from an identification mode, in which low addresses read back fixed manufacturer and device codes.

Any write that is not a valid key step and is not a sector word load gives a single-cycle "unexpected write" pulse. The surrounding model uses that pulse to start its busy timer without storing data. Once a sector load is armed, later writes are treated as data words and are not decoded. The protected state returns when the model signals that the program cycle has ended. A change of identification mode takes effect only after a settle delay, counted in clock cycles, that is set by a parameter.

Top module: `flash_unlock_decoder`

## Requirements
- R1: Synchronous active-high reset clears `load_en`, `stray_wr` and `id_mode` and leaves the decoder idle and protected, so that the first lone write afterwards raises `stray_wr`.
- R2: The writes 0xAAAA to address 0x5555, then 0x5555 to address 0x2AAA, then 0xA0A0 to address 0x5555 raise `load_en` for exactly one cycle, the cycle after the third write is sampled. None of the three writes raises `stray_wr`.
- R3: Command addresses are compared on bits 14..0 only, so bit 15 of `wr_addr` has no effect. All 16 bits of the data word are compared.
- R4: While a sector load is armed, writes raise neither `stray_wr` nor `load_en`, and a repeated full key does not re-arm.
- R5: A `prog_done` pulse ends an armed load, after which an unmatched write raises `stray_wr` again. A `prog_done` pulse while protected has no effect.
- R6: A write that does not match the expected key step, including a third write whose address is correct but whose data is not a known command, raises `stray_wr` in the next cycle and returns the decoder to idle.
- R7: A mismatching write that is itself a valid first step (0xAAAA to 0x5555) restarts the key as its first step, without raising `stray_wr`.
- R8: A final word of 0x9090 sets `id_mode`, and a final word of 0xF0F0 clears it. In both cases `id_mode` changes exactly SETTLE_CYC cycles after the final write is sampled and stays stable at all other times.
- R9: With `id_mode` high and `rd_addr[15:1]` zero, `id_hit` is 1 and `id_data` is 0x001F when `rd_addr[0]` is 0 and 0x0026 when it is 1. In every other case `id_hit` is 0 and `id_data` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe per completed write cycle |
| wr_addr | input | 16 | Latched address of the write |
| wr_data | input | 16 | Latched data word of the write |
| prog_done | input | 1 | Pulse marking the end of a program cycle |
| rd_addr | input | 16 | Current read address, used for identification reads |
| load_en | output | 1 | One-shot enable that opens the sector word load |
| stray_wr | output | 1 | Pulse for a write outside any key; starts the busy timer |
| id_mode | output | 1 | Identification mode is active |
| id_hit | output | 1 | The read address selects an identification code |
| id_data | output | 16 | Identification code for the read address, zero otherwise |

## Verification
The assertions assume that `wr_stb` marks a write for exactly one cycle, and that `prog_done` is only meaningful after a load has been armed. They do not constrain `prog_done`, so a pulse while protected must be harmless. The stimulus drives every write as an isolated one-cycle strobe with an idle cycle after it. It raises `prog_done` both while armed and while protected, and it holds `rd_addr` steady while it samples the identification outputs. The settle window is checked one cycle before and on the cycle the mode flips, using a short settle delay.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [DW-1:0]    KEY_DATA_A = 16'hAAAA;
    localparam logic [DW-1:0]    KEY_DATA_B = 16'h5555;
    localparam logic [DW-1:0]    CMD_PROG   = 16'hA0A0;
    localparam logic [DW-1:0]    CMD_ID_ON  = 16'h9090;
    localparam logic [DW-1:0]    CMD_ID_OFF = 16'hF0F0;
    localparam logic [DW-1:0]    MFR_CODE   = 16'h001F;
    localparam logic [DW-1:0]    DEV_CODE   = 16'h0026;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_ONE,
        KEY_TWO
    } key_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_STEP,
        EV_PROG,
        EV_ID_ON,
        EV_ID_OFF,
        EV_STRAY
    } key_event_e;

    typedef struct packed {
        logic [CMP_W-1:0] addr;
        logic [DW-1:0]    data;
    } wr_word_t;

    function automatic logic is_word(wr_word_t w, logic [CMP_W-1:0] a, logic [DW-1:0] d);
        return (w.addr == a) && (w.data == d);
    endfunction

endpackage

// File: rtl/fcd_key_tracker.sv
module fcd_key_tracker
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  wr_word_t   wr,
    input  logic       hold,
    output key_event_e evt
);

    key_state_e state, nxt;
    logic first_ok, second_ok, final_addr_ok;

    always_comb begin
        first_ok      = is_word(wr, KEY_ADDR_A, KEY_DATA_A);
        second_ok     = is_word(wr, KEY_ADDR_B, KEY_DATA_B);
        final_addr_ok = (wr.addr == KEY_ADDR_A);
    end

    always_comb begin
        nxt = state;
        evt = EV_NONE;
        if (hold) begin
            nxt = KEY_IDLE;
        end else if (wr_stb) begin
            unique case (state)
                KEY_IDLE: begin
                    if (first_ok) begin
                        nxt = KEY_ONE;
                        evt = EV_STEP;
                    end else begin
                        evt = EV_STRAY;
                    end
                end
                KEY_ONE: begin
                    if (second_ok) begin
                        nxt = KEY_TWO;
                        evt = EV_STEP;
                    end else if (first_ok) begin
                        nxt = KEY_ONE;
                        evt = EV_STEP;
                    end else begin
                        nxt = KEY_IDLE;
                        evt = EV_STRAY;
                    end
                end
                KEY_TWO: begin
                    nxt = KEY_IDLE;
                    if (final_addr_ok && wr.data == CMD_PROG) begin
                        evt = EV_PROG;
                    end else if (final_addr_ok && wr.data == CMD_ID_ON) begin
                        evt = EV_ID_ON;
                    end else if (final_addr_ok && wr.data == CMD_ID_OFF) begin
                        evt = EV_ID_OFF;
                    end else if (first_ok) begin
                        nxt = KEY_ONE;
                        evt = EV_STEP;
                    end else begin
                        evt = EV_STRAY;
                    end
                end
                default: nxt = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= KEY_IDLE;
        else     state <= nxt;
    end

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (state == KEY_IDLE));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !hold && first_ok) |=> (state == KEY_ONE));

endmodule

// File: rtl/fcd_mode_ctrl.sv
module fcd_mode_ctrl
    import fcd_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  key_event_e evt,
    input  logic       prog_done,
    output logic       loading,
    output logic       load_en,
    output logic       stray_wr,
    output logic       id_mode
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

    logic             pend;
    logic             tgt;
    logic [CNT_W-1:0] cnt;
    logic             id_cmd;

    always_comb id_cmd = (evt == EV_ID_ON) || (evt == EV_ID_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            loading  <= 1'b0;
            load_en  <= 1'b0;
            stray_wr <= 1'b0;
            id_mode  <= 1'b0;
            pend     <= 1'b0;
            tgt      <= 1'b0;
            cnt      <= '0;
        end else begin
            load_en  <= (evt == EV_PROG);
            stray_wr <= (evt == EV_STRAY);
            if (evt == EV_PROG)  loading <= 1'b1;
            else if (prog_done)  loading <= 1'b0;
            if (id_cmd) begin
                pend <= 1'b1;
                tgt  <= (evt == EV_ID_ON);
                cnt  <= CNT_LOAD;
            end else if (pend) begin
                if (cnt == '0) begin
                    id_mode <= tgt;
                    pend    <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R2
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !load_en);

    // R2
    load_arms_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |-> loading);

    // R5
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_done && loading) |=> !loading);

    // R6
    excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stray_wr |-> !load_en);

    // R8
    id_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend && !id_cmd) |=> $stable(id_mode));

endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom
    import fcd_pkg::*;
(
    input  logic          id_mode,
    input  logic [AW-1:0] rd_addr,
    output logic          id_hit,
    output logic [DW-1:0] id_data
);

    always_comb begin
        id_hit  = id_mode && (rd_addr[AW-1:1] == '0);
        id_data = '0;
        if (id_hit) id_data = rd_addr[0] ? DEV_CODE : MFR_CODE;
    end

endmodule

// File: rtl/flash_unlock_decoder.sv
module flash_unlock_decoder
    import fcd_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          prog_done,
    input  logic [AW-1:0] rd_addr,
    output logic          load_en,
    output logic          stray_wr,
    output logic          id_mode,
    output logic          id_hit,
    output logic [DW-1:0] id_data
);

    wr_word_t   wr;
    key_event_e evt;
    logic       loading;
    logic       unused_addr_hi;

    always_comb begin
        wr.addr        = wr_addr[CMP_W-1:0];
        wr.data        = wr_data;
        unused_addr_hi = wr_addr[AW-1];
    end

    fcd_key_tracker u_key (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .wr     (wr),
        .hold   (loading),
        .evt    (evt)
    );

    fcd_mode_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .prog_done (prog_done),
        .loading   (loading),
        .load_en   (load_en),
        .stray_wr  (stray_wr),
        .id_mode   (id_mode)
    );

    fcd_id_rom u_rom (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .id_hit  (id_hit),
        .id_data (id_data)
    );

    // R9
    id_hit_mode_chk: assert property (@(posedge clk) disable iff (rst)
        id_hit |-> id_mode);

    // R4
    no_stray_loading_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && loading) |=> !stray_wr && !load_en);

endmodule

// File: tb/sim_flash_unlock_decoder.sv
module sim_flash_unlock_decoder;

    localparam int CLK_P  = 10;
    localparam int SETTLE = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        prog_done = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        load_en, stray_wr, id_mode, id_hit;
    logic [15:0] id_data;

    int checks = 0;
    int errors = 0;
    bit summary_done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    flash_unlock_decoder #(.SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_done(prog_done), .rd_addr(rd_addr),
        .load_en(load_en), .stray_wr(stray_wr), .id_mode(id_mode),
        .id_hit(id_hit), .id_data(id_data)
    );

    // {req, addr, data, exp load_en, exp stray_wr}
    localparam logic [37:0] VEC [16] = '{
        {4'd1, 16'h1234, 16'h0000, 1'b0, 1'b1},  // R1 protected after reset
        {4'd2, 16'h5555, 16'hAAAA, 1'b0, 1'b0},
        {4'd6, 16'h1111, 16'h5555, 1'b0, 1'b1},  // R6 wrong address
        {4'd6, 16'h2AAA, 16'h5555, 1'b0, 1'b1},  // R6 step two from idle
        {4'd2, 16'h5555, 16'hAAAA, 1'b0, 1'b0},
        {4'd7, 16'h5555, 16'hAAAA, 1'b0, 1'b0},  // R7 restart from step one
        {4'd2, 16'h2AAA, 16'h5555, 1'b0, 1'b0},
        {4'd7, 16'h5555, 16'hAAAA, 1'b0, 1'b0},  // R7 restart from step two
        {4'd2, 16'h2AAA, 16'h5555, 1'b0, 1'b0},
        {4'd6, 16'h5555, 16'h1234, 1'b0, 1'b1},  // R6 unknown final word
        {4'd3, 16'hD555, 16'hAAAA, 1'b0, 1'b0},  // R3 bit 15 ignored
        {4'd3, 16'hAAAA, 16'h5555, 1'b0, 1'b0},  // R3
        {4'd3, 16'h5555, 16'hA0A1, 1'b0, 1'b1},  // R3 full data compare
        {4'd2, 16'h5555, 16'hAAAA, 1'b0, 1'b0},
        {4'd2, 16'h2AAA, 16'h5555, 1'b0, 1'b0},
        {4'd2, 16'hD555, 16'hA0A0, 1'b1, 1'b0}   // R2 arm
    };

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic do_key(input logic [15:0] fin);
        do_wr(16'h5555, 16'hAAAA);
        do_wr(16'h2AAA, 16'h5555);
        do_wr(16'h5555, fin);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        prog_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(load_en == 1'b0, "R1 load_en", {15'b0, load_en}, 16'h0);
        chk(stray_wr == 1'b0, "R1 stray_wr", {15'b0, stray_wr}, 16'h0);
        chk(id_mode == 1'b0, "R1 id_mode", {15'b0, id_mode}, 16'h0);
        chk(id_hit == 1'b0, "R1 id_hit", {15'b0, id_hit}, 16'h0);

        for (int i = 0; i < 16; i++) begin
            do_wr(VEC[i][33:18], VEC[i][17:2]);
            chk(load_en == VEC[i][1], $sformatf("R%0d vec %0d load_en", VEC[i][37:34], i),
                {15'b0, load_en}, {15'b0, VEC[i][1]});
            chk(stray_wr == VEC[i][0], $sformatf("R%0d vec %0d stray_wr", VEC[i][37:34], i),
                {15'b0, stray_wr}, {15'b0, VEC[i][0]});
        end
        @(negedge clk);
        chk(load_en == 1'b0, "R2 load_en one cycle", {15'b0, load_en}, 16'h0);

        // R4 armed: data words and a repeated key are not decoded
        do_wr(16'h0100, 16'hBEEF);
        chk(stray_wr == 1'b0, "R4 word load stray", {15'b0, stray_wr}, 16'h0);
        do_wr(16'h5555, 16'hAAAA);
        chk(stray_wr == 1'b0, "R4 key1 stray", {15'b0, stray_wr}, 16'h0);
        do_wr(16'h2AAA, 16'h5555);
        do_wr(16'h5555, 16'hA0A0);
        chk(load_en == 1'b0, "R4 no re-arm", {15'b0, load_en}, 16'h0);
        chk(stray_wr == 1'b0, "R4 final stray", {15'b0, stray_wr}, 16'h0);

        // R5 end of program cycle restores protection
        pulse_done();
        do_wr(16'h0100, 16'hBEEF);
        chk(stray_wr == 1'b1, "R5 stray after done", {15'b0, stray_wr}, 16'h1);
        pulse_done();
        do_wr(16'h0102, 16'h0000);
        chk(stray_wr == 1'b1, "R5 done while protected", {15'b0, stray_wr}, 16'h1);

        // R8 entry with settle delay
        do_key(16'h9090);
        chk(stray_wr == 1'b0, "R8 entry stray", {15'b0, stray_wr}, 16'h0);
        repeat (SETTLE - 1) @(posedge clk);
        @(negedge clk);
        chk(id_mode == 1'b0, "R8 before settle", {15'b0, id_mode}, 16'h0);
        @(posedge clk);
        @(negedge clk);
        chk(id_mode == 1'b1, "R8 after settle", {15'b0, id_mode}, 16'h1);

        // R9 identification reads
        rd_addr = 16'h0000;
        #1;
        chk(id_hit == 1'b1 && id_data == 16'h001F, "R9 mfr code", id_data, 16'h001F);
        rd_addr = 16'h0001;
        #1;
        chk(id_hit == 1'b1 && id_data == 16'h0026, "R9 dev code", id_data, 16'h0026);
        rd_addr = 16'h0002;
        #1;
        chk(id_hit == 1'b0 && id_data == 16'h0000, "R9 addr 2", id_data, 16'h0000);
        rd_addr = 16'h8000;
        #1;
        chk(id_hit == 1'b0 && id_data == 16'h0000, "R9 addr 8000", id_data, 16'h0000);
        rd_addr = 16'h0000;

        // R8 exit with settle delay
        do_key(16'hF0F0);
        repeat (SETTLE - 1) @(posedge clk);
        @(negedge clk);
        chk(id_mode == 1'b1, "R8 exit before settle", {15'b0, id_mode}, 16'h1);
        @(posedge clk);
        @(negedge clk);
        chk(id_mode == 1'b0, "R8 exit after settle", {15'b0, id_mode}, 16'h0);
        chk(id_hit == 1'b0 && id_data == 16'h0000, "R9 outside id mode", id_data, 16'h0000);

        // R1 reset leaves identification mode
        do_key(16'h9090);
        repeat (SETTLE + 1) @(posedge clk);
        @(negedge clk);
        chk(id_mode == 1'b1, "R8 re-entry", {15'b0, id_mode}, 16'h1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(id_mode == 1'b0, "R1 reset clears id_mode", {15'b0, id_mode}, 16'h0);
        do_wr(16'h2AAA, 16'h5555);
        chk(stray_wr == 1'b1, "R1 idle after reset", {15'b0, stray_wr}, 16'h1);

        finish_run();
    end

endmodule